// File: doc/BRIEF.md
# USB Device Controller Register Block

This block is the software-visible register file of a single-port USB device controller with on-the-go support. A processor reaches it over a simple 32-bit word bus: one write strobe, one read strobe and a 9-bit word offset. Reads return their data one clock later, with a one-cycle error flag for offsets that map to nothing. The block returns fixed identity and capability words. It holds the command, status, interrupt-enable, device-address, endpoint-list-base, port-status, OTG control/status, setup-status, endpoint-ready and endpoint-complete registers.

The neighbouring logic signals events on side inputs. These are the start and end of a bus reset, setup packets arriving per endpoint, completed transfers per endpoint and direction, and OTG status events. The block combines two separately masked status sources into one registered, level-sensitive interrupt line. The register offsets are fixed because driver software decodes them.

Top module: `usbdev_ctrl_regs`

## Requirements
- R1: After reset the command register (0x140) reads 0x00080000, port status (0x184) reads 0xEC000004, OTG (0x1A4) reads 0x00000F20, and status (0x144), interrupt enable (0x148), device address (0x154), endpoint list base (0x158), setup status (0x1AC), endpoint ready (0x1B8) and endpoint complete (0x1BC) read zero.
- R2: A command write with bit 1 set returns every register to its R1 value in place of storing; any other command write stores the word unchanged.
- R3: Writing the status register clears each bit written as one. A write to the interrupt enable register keeps only the bits of 0x030101D7.
- R4: The irq output goes high on the clock edge after (status AND enable) is nonzero, or after an OTG status bit 16+k (k = 0..6) and its enable bit 24+k are both set. It drops in the same way.
- R5: An OTG write replaces only the bits in 0x7F00003B. Every bit written as one in 22:16 then clears that OTG status bit. The side input otg_evt[k] sets OTG bit 16+k.
- R6: The device address register keeps only bits 31:25. The endpoint list base keeps only bits 31:11.
- R7: A bus_rst_start pulse clears port bit 0, sets port bits 27, 26 and 8, zeroes the device address, sets status bit 6 and clears the endpoint ready register.
- R8: A bus_rst_end pulse clears port bits 27, 26 and 8, sets port bit 0 and sets status bit 2. When it arrives in the same cycle as bus_rst_start, it is applied after that pulse.
- R9: A write to 0x1B0 sets ready bits from wdata bits 3:0 (receive) and 19:16 (transmit). A write to 0x1B4 clears the ready bits written as one. ep_done[i] sets complete bit i (i < 4) or bit 12+i (i >= 4) and clears the same ready bit; it takes priority over a write in the same cycle.
- R10: Setup status and endpoint complete are write-one-to-clear. ep_setup[i] sets setup bit i, and an event wins over a clear in the same cycle.
- R11: Identity reads: 0x000 gives 0x0042FA05, 0x100 gives 0x01000040, 0x124 gives 0x00000184, and 0x1C0 gives 0x00800080.
- R12: A read of an unmapped offset returns zero with rd_err high for one cycle. Writes to port status (0x184), mode (0x1A8) and endpoint control (0x1C0-0x1CC) change nothing.
- R13: rdata and rd_err are registered. They show the register value from before any write or event in the same cycle, and rdata is zero when no read was issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 9 | Byte offset of the word accessed |
| wdata | input | 32 | Write data |
| bus_rst_start | input | 1 | Bus reset began (one-cycle pulse) |
| bus_rst_end | input | 1 | Bus reset ended (one-cycle pulse) |
| ep_setup | input | 4 | Setup packet received, per endpoint |
| ep_done | input | 8 | Transfer completed: receive endpoints low, transmit high |
| otg_evt | input | 7 | OTG status events |
| rdata | output | 32 | Read data, one cycle after rd_en |
| rd_err | output | 1 | Unmapped read, one cycle after rd_en |
| irq | output | 1 | Registered level interrupt |

## Verification
The bench goes after the mixed OTG word. A design that treats all of it as plain read/write would lose the clear behaviour of bits 22:16, and one that drops the mask would let software set status bits. It also drives same-cycle collisions: event against clear, a bus-reset start together with its end, and a command reset against pending events. A design with the wrong priority leaves stale ready, setup or port bits. The one-cycle lag of irq is checked every cycle, so an unregistered or mis-masked interrupt shows up as an early, late or spurious level. Ignored writes are read back to show that no port or control bit moved.

// File: rtl/usbdev_pkg.sv
package usbdev_pkg;

    localparam int OFF_W = 9;

    localparam logic [OFF_W-1:0] A_CMD     = 9'h140;
    localparam logic [OFF_W-1:0] A_STS     = 9'h144;
    localparam logic [OFF_W-1:0] A_INTR    = 9'h148;
    localparam logic [OFF_W-1:0] A_DEVADDR = 9'h154;
    localparam logic [OFF_W-1:0] A_EPLIST  = 9'h158;
    localparam logic [OFF_W-1:0] A_PORT    = 9'h184;
    localparam logic [OFF_W-1:0] A_OTG     = 9'h1A4;
    localparam logic [OFF_W-1:0] A_MODE    = 9'h1A8;
    localparam logic [OFF_W-1:0] A_SETUP   = 9'h1AC;
    localparam logic [OFF_W-1:0] A_PRIME   = 9'h1B0;
    localparam logic [OFF_W-1:0] A_FLUSH   = 9'h1B4;
    localparam logic [OFF_W-1:0] A_READY   = 9'h1B8;
    localparam logic [OFF_W-1:0] A_DONE    = 9'h1BC;
    localparam logic [OFF_W-1:0] A_EPCTL0  = 9'h1C0;

    localparam logic [31:0] CMD_RST   = 32'h0008_0000;
    localparam logic [31:0] PORT_RST  = 32'hEC00_0004;
    localparam logic [31:0] OTG_RST   = 32'h0000_0F20;

    localparam logic [31:0] INTR_KEEP   = 32'h0301_01D7;
    localparam logic [31:0] OTG_RW      = 32'h7F00_003B;
    localparam logic [31:0] OTG_W1C     = 32'h007F_0000;
    localparam logic [31:0] DEVADDR_KEEP = 32'hFE00_0000;
    localparam logic [31:0] EPLIST_KEEP  = 32'hFFFF_F800;
    localparam logic [31:0] PORT_INRST   = 32'h0C00_0100;

    localparam logic [31:0] EPCTL0_WORD = 32'h0080_0080;

    typedef struct packed {
        logic [31:0] cmd;
        logic [31:0] sts;
        logic [31:0] intr;
        logic [31:0] devaddr;
        logic [31:0] eplist;
        logic [31:0] port;
        logic [31:0] otg;
        logic [31:0] setup;
        logic [31:0] ready;
        logic [31:0] done;
        logic [31:0] rdata;
        logic        rderr;
        logic        irq;
    } regs_t;

endpackage

// File: rtl/usbdev_id_rom.sv
module usbdev_id_rom
    import usbdev_pkg::*;
#(
    parameter int NUM_EP = 4
) (
    input  logic [OFF_W-1:0] addr,
    output logic             hit,
    output logic [31:0]      word
);
    localparam logic [31:0] DC_PARAMS = 32'h0000_0180 | 32'(NUM_EP);

    always_comb begin
        hit  = 1'b1;
        word = '0;
        case (addr)
            9'h000: word = 32'h0042_FA05;
            9'h004: word = 32'h0000_02C5;
            9'h008: word = 32'h1002_0001;
            9'h00C: word = 32'h0000_0009;
            9'h010: word = 32'h8005_0708;
            9'h014: word = 32'h0000_0508;
            9'h100: word = 32'h0100_0040;
            9'h104: word = 32'h0001_0011;
            9'h108: word = 32'h0000_0006;
            9'h10C: word = 32'h0000_0000;
            9'h120: word = 32'h0000_0001;
            9'h124: word = DC_PARAMS;
            default: hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/usbdev_irq_merge.sv
module usbdev_irq_merge #(
    parameter int OTG_SRC = 7
) (
    input  logic [31:0] sts,
    input  logic [31:0] intr,
    input  logic [31:0] otg,
    output logic        req
);
    logic [OTG_SRC-1:0] otg_hit;

    for (genvar k = 0; k < OTG_SRC; k++) begin : g_otg
        assign otg_hit[k] = otg[16+k] & otg[24+k];
    end

    assign req = (|(sts & intr)) | (|otg_hit);
endmodule

// File: rtl/usbdev_ctrl_regs.sv
module usbdev_ctrl_regs
    import usbdev_pkg::*;
#(
    parameter int NUM_EP  = 4,
    parameter int OTG_SRC = 7
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic                rd_en,
    input  logic [OFF_W-1:0]    addr,
    input  logic [31:0]         wdata,
    input  logic                bus_rst_start,
    input  logic                bus_rst_end,
    input  logic [NUM_EP-1:0]   ep_setup,
    input  logic [2*NUM_EP-1:0] ep_done,
    input  logic [OTG_SRC-1:0]  otg_evt,
    output logic [31:0]         rdata,
    output logic                rd_err,
    output logic                irq
);
    localparam logic [31:0] RX_BITS = 32'((64'd1 << NUM_EP) - 1);
    localparam logic [31:0] EP_KEEP = RX_BITS | (RX_BITS << 16);
    localparam regs_t       RST_VAL = '{cmd: CMD_RST, port: PORT_RST, otg: OTG_RST, default: '0};

    regs_t q, d;

    logic        id_hit;
    logic [31:0] id_word;
    logic        irq_req;
    logic        epc_hit;
    logic [31:0] epc_word;

    usbdev_id_rom #(.NUM_EP(NUM_EP)) u_rom (
        .addr (addr),
        .hit  (id_hit),
        .word (id_word)
    );

    usbdev_irq_merge #(.OTG_SRC(OTG_SRC)) u_irq (
        .sts  (q.sts),
        .intr (q.intr),
        .otg  (q.otg),
        .req  (irq_req)
    );

    // endpoint control words: one per endpoint, only the first is nonzero
    always_comb begin
        epc_hit  = 1'b0;
        epc_word = '0;
        for (int i = 0; i < NUM_EP; i++) begin
            if (addr == OFF_W'(int'(A_EPCTL0) + 4*i)) begin
                epc_hit  = 1'b1;
                epc_word = (i == 0) ? EPCTL0_WORD : 32'h0;
            end
        end
    end

    always_comb begin
        logic cmd_reset;
        d         = q;
        d.rdata   = '0;
        d.rderr   = 1'b0;
        cmd_reset = 1'b0;

        // read path sees the current state only
        if (rd_en) begin
            if (id_hit) begin
                d.rdata = id_word;
            end else if (epc_hit) begin
                d.rdata = epc_word;
            end else begin
                case (addr)
                    A_CMD:     d.rdata = q.cmd;
                    A_STS:     d.rdata = q.sts;
                    A_INTR:    d.rdata = q.intr;
                    A_DEVADDR: d.rdata = q.devaddr;
                    A_EPLIST:  d.rdata = q.eplist;
                    A_PORT:    d.rdata = q.port;
                    A_OTG:     d.rdata = q.otg;
                    A_SETUP:   d.rdata = q.setup;
                    A_READY:   d.rdata = q.ready;
                    A_DONE:    d.rdata = q.done;
                    A_MODE, A_PRIME, A_FLUSH: d.rdata = '0;
                    default:   d.rderr = 1'b1;
                endcase
            end
        end

        // software writes
        if (wr_en) begin
            case (addr)
                A_CMD: begin
                    if (wdata[1]) cmd_reset = 1'b1;
                    else          d.cmd = wdata;
                end
                A_STS:     d.sts     = q.sts & ~wdata;
                A_INTR:    d.intr    = wdata & INTR_KEEP;
                A_DEVADDR: d.devaddr = wdata & DEVADDR_KEEP;
                A_EPLIST:  d.eplist  = wdata & EPLIST_KEEP;
                A_OTG: begin
                    d.otg = (q.otg & ~OTG_RW) | (wdata & OTG_RW);
                    d.otg = d.otg & ~(wdata & OTG_W1C);
                end
                A_SETUP:   d.setup = q.setup & ~wdata;
                A_PRIME:   d.ready = q.ready | (wdata & EP_KEEP);
                A_FLUSH:   d.ready = q.ready & ~wdata;
                A_DONE:    d.done  = q.done & ~wdata;
                default: ;
            endcase
        end

        // hardware events override same-cycle writes
        d.setup = d.setup | 32'(ep_setup);
        for (int i = 0; i < 2*NUM_EP; i++) begin
            if (ep_done[i]) begin
                d.done[(i < NUM_EP) ? i : (16 + i - NUM_EP)]  = 1'b1;
                d.ready[(i < NUM_EP) ? i : (16 + i - NUM_EP)] = 1'b0;
            end
        end
        d.otg[16 +: OTG_SRC] = d.otg[16 +: OTG_SRC] | otg_evt;

        if (bus_rst_start) begin
            d.port    = (d.port & ~32'h1) | PORT_INRST;
            d.devaddr = '0;
            d.sts[6]  = 1'b1;
            d.ready   = '0;
        end
        if (bus_rst_end) begin
            d.port   = (d.port & ~PORT_INRST) | 32'h1;
            d.sts[2] = 1'b1;
        end

        if (cmd_reset) begin
            d.cmd     = CMD_RST;
            d.sts     = '0;
            d.intr    = '0;
            d.devaddr = '0;
            d.eplist  = '0;
            d.port    = PORT_RST;
            d.otg     = OTG_RST;
            d.setup   = '0;
            d.ready   = '0;
            d.done    = '0;
        end

        d.irq = irq_req;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= RST_VAL;
        else        q <= d;
    end

    assign rdata  = q.rdata;
    assign rd_err = q.rderr;
    assign irq    = q.irq;
endmodule

// File: rtl/usbdev_ctrl_regs_chk.sv
module usbdev_ctrl_regs_chk
    import usbdev_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             rd_en,
    input logic [OFF_W-1:0] addr,
    input logic [31:0]      wdata,
    input logic             bus_rst_start,
    input logic             bus_rst_end,
    input logic             rd_err,
    input logic             irq,
    input logic [31:0]      sts,
    input logic [31:0]      intr,
    input logic [31:0]      otg,
    input logic [31:0]      port,
    input logic [31:0]      devaddr
);
    logic cmd_rst;
    assign cmd_rst = wr_en && (addr == A_CMD) && wdata[1];

    a_r4_irq_lags_state: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> irq == $past((|(sts & intr)) || (|(otg[22:16] & otg[30:24]))));

    a_r2_cmd_reset: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_rst |=> (port == PORT_RST) && (otg == OTG_RST) && (sts == 32'h0));

    a_r3_intr_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_INTR && !cmd_rst) |=> intr == ($past(wdata) & INTR_KEEP));

    a_r7_bus_start: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rst_start && !bus_rst_end && !cmd_rst) |=>
            (devaddr == 32'h0) && sts[6] && port[8] && port[27] && port[26] && !port[0]);

    a_r8_bus_end: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rst_end && !cmd_rst) |=> port[0] && !port[8] && sts[2]);

    a_r12_err_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
        rd_err |-> $past(rd_en));
endmodule

bind usbdev_ctrl_regs usbdev_ctrl_regs_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_en         (wr_en),
    .rd_en         (rd_en),
    .addr          (addr),
    .wdata         (wdata),
    .bus_rst_start (bus_rst_start),
    .bus_rst_end   (bus_rst_end),
    .rd_err        (rd_err),
    .irq           (irq),
    .sts           (q.sts),
    .intr          (q.intr),
    .otg           (q.otg),
    .port          (q.port),
    .devaddr       (q.devaddr)
);

// File: tb/sim_usbdev_ctrl_regs.sv
`timescale 1ns/1ps
module sim_usbdev_ctrl_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [8:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic        bus_rst_start = 1'b0, bus_rst_end = 1'b0;
    logic [3:0]  ep_setup = '0;
    logic [7:0]  ep_done = '0;
    logic [6:0]  otg_evt = '0;
    logic [31:0] rdata;
    logic        rd_err, irq;

    int checks = 0, errors = 0;
    int cyc_cnt = 0;

    always #5 clk = ~clk;

    usbdev_ctrl_regs u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .bus_rst_start(bus_rst_start), .bus_rst_end(bus_rst_end),
        .ep_setup(ep_setup), .ep_done(ep_done), .otg_evt(otg_evt),
        .rdata(rdata), .rd_err(rd_err), .irq(irq)
    );

    // expected-state model built from the requirements
    logic [31:0] m_cmd, m_sts, m_intr, m_dev, m_epl, m_port, m_otg, m_setup, m_ready, m_done;

    task automatic m_reset();
        m_cmd = 32'h0008_0000; m_port = 32'hEC00_0004; m_otg = 32'h0000_0F20;
        m_sts = 0; m_intr = 0; m_dev = 0; m_epl = 0; m_setup = 0; m_ready = 0; m_done = 0;
    endtask

    function automatic logic m_irq();
        return (|(m_sts & m_intr)) || (|(m_otg[22:16] & m_otg[30:24]));
    endfunction

    function automatic logic [32:0] m_read(input logic [8:0] a);
        case (a)
            9'h000: return {1'b0, 32'h0042_FA05};
            9'h004: return {1'b0, 32'h0000_02C5};
            9'h008: return {1'b0, 32'h1002_0001};
            9'h00C: return {1'b0, 32'h0000_0009};
            9'h010: return {1'b0, 32'h8005_0708};
            9'h014: return {1'b0, 32'h0000_0508};
            9'h100: return {1'b0, 32'h0100_0040};
            9'h104: return {1'b0, 32'h0001_0011};
            9'h108: return {1'b0, 32'h0000_0006};
            9'h10C, 9'h1A8, 9'h1B0, 9'h1B4, 9'h1C4, 9'h1C8, 9'h1CC: return 33'h0;
            9'h120: return {1'b0, 32'h0000_0001};
            9'h124: return {1'b0, 32'h0000_0184};
            9'h1C0: return {1'b0, 32'h0080_0080};
            9'h140: return {1'b0, m_cmd};
            9'h144: return {1'b0, m_sts};
            9'h148: return {1'b0, m_intr};
            9'h154: return {1'b0, m_dev};
            9'h158: return {1'b0, m_epl};
            9'h184: return {1'b0, m_port};
            9'h1A4: return {1'b0, m_otg};
            9'h1AC: return {1'b0, m_setup};
            9'h1B8: return {1'b0, m_ready};
            9'h1BC: return {1'b0, m_done};
            default: return {1'b1, 32'h0};
        endcase
    endfunction

    task automatic m_step(input bit wr, input logic [8:0] a, input logic [31:0] wd, input bit bs,
                          input bit be, input logic [3:0] su, input logic [7:0] dn, input logic [6:0] oe);
        bit rs = 0;
        if (wr) begin
            case (a)
                9'h140: if (wd[1]) rs = 1; else m_cmd = wd;
                9'h144: m_sts &= ~wd;
                9'h148: m_intr = wd & 32'h0301_01D7;
                9'h154: m_dev = wd & 32'hFE00_0000;
                9'h158: m_epl = wd & 32'hFFFF_F800;
                9'h1A4: m_otg = ((m_otg & ~32'h7F00_003B) | (wd & 32'h7F00_003B)) & ~(wd & 32'h007F_0000);
                9'h1AC: m_setup &= ~wd;
                9'h1B0: m_ready |= wd & 32'h000F_000F;
                9'h1B4: m_ready &= ~wd;
                9'h1BC: m_done &= ~wd;
                default: ;
            endcase
        end
        m_setup |= {28'h0, su};
        m_done  |= {12'h0, dn[7:4], 12'h0, dn[3:0]};
        m_ready &= ~{12'h0, dn[7:4], 12'h0, dn[3:0]};
        m_otg   |= {9'h0, oe, 16'h0};
        if (bs) begin m_port = (m_port & ~32'h1) | 32'h0C00_0100; m_dev = 0; m_sts |= 32'h40; m_ready = 0; end
        if (be) begin m_port = (m_port & ~32'h0C00_0100) | 32'h1; m_sts |= 32'h4; end
        if (rs) m_reset();
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cyc(input string tag, input bit wr, input bit rd, input logic [8:0] a,
                       input logic [31:0] wd, input bit bs = 0, input bit be = 0,
                       input logic [3:0] su = 0, input logic [7:0] dn = 0, input logic [6:0] oe = 0);
        logic [32:0] er;
        logic        ei;
        @(negedge clk);
        wr_en = wr; rd_en = rd; addr = a; wdata = wd;
        bus_rst_start = bs; bus_rst_end = be; ep_setup = su; ep_done = dn; otg_evt = oe;
        er = rd ? m_read(a) : 33'h0;
        ei = m_irq();
        m_step(wr, a, wd, bs, be, su, dn, oe);
        @(posedge clk); #2;
        check(tag, rdata, er[31:0]);
        check("R12 rd_err", {31'h0, rd_err}, {31'h0, er[32]});
        check("R4 irq", {31'h0, irq}, {31'h0, ei});
    endtask

    task automatic rd(input string tag, input logic [8:0] a);
        cyc(tag, 0, 1, a, 0);
    endtask

    task automatic wr(input string tag, input logic [8:0] a, input logic [31:0] d);
        cyc(tag, 1, 0, a, d);
    endtask

    localparam int NOFF = 24;
    logic [8:0] offs [NOFF] = '{9'h000, 9'h100, 9'h124, 9'h140, 9'h144, 9'h148, 9'h154, 9'h158,
                                9'h184, 9'h1A4, 9'h1A8, 9'h1AC, 9'h1B0, 9'h1B4, 9'h1B8, 9'h1BC,
                                9'h1C0, 9'h1C4, 9'h1CC, 9'h148, 9'h1A4, 9'h144, 9'h1B0, 9'h1F0};

    initial begin : watchdog
        forever begin
            @(posedge clk);
            cyc_cnt++;
            if (cyc_cnt > 100000) begin
                errors++; checks++;
                $display("FAIL watchdog: actual=%0d expected<=100000 cycles", cyc_cnt);
                $display("Result: errors=%0d of %0d checks", errors, checks);
                $finish;
            end
        end
    end

    initial begin
        logic [31:0] seed;
        m_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1 reset values
        foreach (offs[i]) if (offs[i] >= 9'h140) rd("R1", offs[i]);

        // R11 identity words
        rd("R11", 9'h000); rd("R11", 9'h100); rd("R11", 9'h124); rd("R11", 9'h1C0);

        // R12 unmapped read and ignored writes
        rd("R12", 9'h1FC);
        wr("R12", 9'h184, 32'hFFFF_FFFF); rd("R12", 9'h184);
        wr("R12", 9'h1C0, 32'h0); rd("R12", 9'h1C0);
        wr("R12", 9'h1A8, 32'h3); rd("R12", 9'h1A8);

        // R3 interrupt mask, R7/R8 bus reset, R4 irq
        wr("R3", 9'h148, 32'hFFFF_FFFF); rd("R3", 9'h148);
        wr("R9", 9'h1B0, 32'hFFFF_FFFF); rd("R9", 9'h1B8);
        wr("R6", 9'h154, 32'hFFFF_FFFF); rd("R6", 9'h154);
        wr("R6", 9'h158, 32'hFFFF_FFFF); rd("R6", 9'h158);
        cyc("R7", 0, 0, 0, 0, 1); rd("R7", 9'h184); rd("R7", 9'h144); rd("R7", 9'h154); rd("R7", 9'h1B8);
        cyc("R8", 0, 0, 0, 0, 0, 1); rd("R8", 9'h184); rd("R8", 9'h144);
        cyc("R8", 0, 0, 0, 0, 1, 1); rd("R8", 9'h184);
        wr("R3", 9'h144, 32'h0000_0040); rd("R3", 9'h144);
        wr("R3", 9'h144, 32'hFFFF_FFFF); rd("R4", 9'h144);

        // R5 OTG mixed access
        cyc("R5", 0, 0, 0, 0, 0, 0, 0, 0, 7'h7F); rd("R5", 9'h1A4);
        wr("R5", 9'h1A4, 32'h0100_0000); rd("R5", 9'h1A4);
        wr("R5", 9'h1A4, 32'h8081_FFC4); rd("R5", 9'h1A4);
        wr("R5", 9'h1A4, 32'h007F_0000); rd("R5", 9'h1A4);

        // R9 / R10 endpoint bookkeeping and collisions
        wr("R9", 9'h1B0, 32'h0005_000A);
        cyc("R9", 0, 0, 0, 0, 0, 0, 0, 8'h21); rd("R9", 9'h1B8); rd("R9", 9'h1BC);
        cyc("R9", 1, 0, 9'h1B0, 32'h0001_0001, 0, 0, 0, 8'h11); rd("R9", 9'h1B8);
        wr("R9", 9'h1B4, 32'h0000_0008); rd("R9", 9'h1B8);
        cyc("R10", 0, 0, 0, 0, 0, 0, 4'h9); rd("R10", 9'h1AC);
        cyc("R10", 1, 0, 9'h1AC, 32'hF, 0, 0, 4'h1); rd("R10", 9'h1AC);
        wr("R10", 9'h1BC, 32'hFFFF_FFFF); rd("R10", 9'h1BC);

        // R13 read sees pre-write value
        cyc("R13", 1, 1, 9'h148, 32'h0, 0, 0); rd("R13", 9'h148);

        // R2 command store and reset
        wr("R2", 9'h140, 32'h1234_5671); rd("R2", 9'h140);
        cyc("R2", 1, 0, 9'h140, 32'h2, 1, 0, 4'hF, 8'hFF, 7'h7F);
        rd("R2", 9'h140); rd("R2", 9'h184); rd("R2", 9'h1A4); rd("R2", 9'h1AC); rd("R2", 9'h1BC);

        // constrained random traffic, fixed seed
        seed = $urandom(32'h5EED_1234);
        for (int n = 0; n < 4000; n++) begin
            logic [31:0] r = $urandom;
            logic [8:0]  a = (r[3:0] == 0) ? 9'($urandom) : offs[$urandom % NOFF];
            logic [31:0] d = $urandom;
            if (a == 9'h140 && r[9:4] != 0) d[1] = 1'b0;
            cyc("R13", r[10], r[11], a, d,
                r[19:14] == 0, r[25:20] == 0,
                (r[13:12] == 0) ? 4'($urandom) : 4'h0,
                (r[27:26] == 0) ? 8'($urandom) : 8'h0,
                (r[29:28] == 0) ? 7'($urandom) : 7'h0);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule